// File: doc/BRIEF.md
# Prioritised Sound Event Interrupt Controller

This block gathers eight numbered event requests from the sound subsystem and drives one fast-interrupt request line to an embedded processor. Internally it keeps a bitmask of pending events. A readable IRQ register reports an event number, and a lower number means a higher priority. The processor acknowledges events by writing to a clear register on a small register bus. The block takes action only on every fourth such write. That action removes the lowest pending event and then points the IRQ register at the next pending event above it.

The same register bus also carries a run/hold control bit for the processor. When software releases the processor from hold, the block emits a one-cycle core-reset pulse and a one-cycle pulse that resets the sample-accounting counters. Out of reset, the timer event (number 2) is already pending and the interrupt line is high.

Top module: `snd_evt_irq`

## Requirements
- R1: After reset, event 2 is the only pending event. The IRQ register reads 2, `fiq_o` is 1, `cpu_hold_o` is 1, both pulse outputs are 0 and the acknowledge count is zero.
- R2: A 1 on `evt_i[n]` in a cycle sets pending bit n. Several events in one cycle all set their bits.
- R3: When events arrive, the IRQ register takes the smallest arriving number if it currently reads 0 or if that number is smaller than its value. Otherwise it keeps its value.
- R4: `fiq_o` is 1 exactly when the pending mask is non-empty, updated one cycle after the event or clear that changes it.
- R5: A write to address 2 advances an acknowledge count. Only the fourth such write performs a clear and resets the count. Writes to other addresses do not advance it.
- R6: A clear removes the lowest-numbered pending bit. The IRQ register then takes the number of the lowest bit still pending. If none remains (or the mask was already empty), the IRQ register keeps its value.
- R7: A write to address 0 loads `wr_data[0]` into the hold bit shown on `cpu_hold_o` in the next cycle. Only a write that changes the bit from 1 to 0 makes `core_rst_o` and `smp_clr_o` high for exactly the following cycle. Any other write to address 0 (0 to 0, 0 to 1, 1 to 1) leaves both outputs at 0.
- R8: `rd_data` is combinational from `rd_addr`. Address 0 returns the hold bit in bit 0. Address 1 returns the IRQ register in bits 2:0. Any other address returns 0. Upper bits are 0.
- R9: If an event and a performing clear fall in the same cycle, the clear acts on the previous mask first. The R3 rule is then applied to the IRQ value left by the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event request strobes, bit n is event n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| fiq_o | output | 1 | Fast-interrupt request to the processor |
| cpu_hold_o | output | 1 | Processor held in reset when 1 |
| core_rst_o | output | 1 | One-cycle core reset pulse on release |
| smp_clr_o | output | 1 | One-cycle sample counter reset pulse on release |

## Verification
The bench builds the block with its defaults: 4-bit addresses, 8-bit data, four writes per acknowledge and event 2 pending after reset. With the small acknowledge count, random write traffic completes many clears, including clears on an empty mask and clears that coincide with new events. The 8-bit event space lets the odd priority rule be reached repeatedly: a stored value of 0 yields to any arriving event, and a stale higher-priority value blocks later events.

// File: rtl/snd_evt_irq_pkg.sv
package snd_evt_irq_pkg;

    localparam int unsigned EVT_N = 8;
    localparam int unsigned IDX_W = $clog2(EVT_N);

    typedef logic [EVT_N-1:0] evt_mask_t;
    typedef logic [IDX_W-1:0] evt_idx_t;

    typedef struct packed {
        logic     valid;
        evt_idx_t idx;
    } evt_pick_t;

    typedef enum logic [1:0] {
        SEL_RUN  = 2'd0,
        SEL_IRQ  = 2'd1,
        SEL_ACK  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    // Lowest-numbered set bit of a mask.
    function automatic evt_pick_t lowest_set(evt_mask_t m);
        evt_pick_t p;
        p.valid = 1'b0;
        p.idx   = '0;
        for (int i = EVT_N - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.valid = 1'b1;
                p.idx   = evt_idx_t'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/snd_evt_ack.sv
module snd_evt_ack
    import snd_evt_irq_pkg::*;
#(
    parameter int unsigned ACK_WRITES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    output logic fire_o,
    output logic [$clog2(ACK_WRITES+1)-1:0] cnt_o
);
    localparam int unsigned CNT_W = $clog2(ACK_WRITES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_WRITES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign fire_o = hit_i && (cnt_q == LAST);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hit_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/snd_evt_pend.sv
module snd_evt_pend
    import snd_evt_irq_pkg::*;
#(
    parameter int unsigned BOOT_EVT = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  evt_mask_t evt_i,
    input  logic      clr_i,
    output evt_mask_t mask_o,
    output evt_idx_t  irq_o,
    output logic      fiq_o
);
    evt_mask_t mask_q, mask_after, mask_d;
    evt_idx_t  irq_q, irq_mid, irq_d;
    logic      fiq_q;
    evt_pick_t rem_pick, arr_pick;

    always_comb begin
        mask_after = mask_q;
        irq_mid    = irq_q;
        if (clr_i) begin
            mask_after = mask_q & (mask_q - 1'b1);
        end
        rem_pick = lowest_set(mask_after);
        if (clr_i && (mask_q != '0) && rem_pick.valid) begin
            irq_mid = rem_pick.idx;
        end
        arr_pick = lowest_set(evt_i);
        irq_d    = irq_mid;
        if (arr_pick.valid && ((irq_mid == '0) || (arr_pick.idx < irq_mid))) begin
            irq_d = arr_pick.idx;
        end
        mask_d = mask_after | evt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= evt_mask_t'(1) << BOOT_EVT;
            irq_q  <= evt_idx_t'(BOOT_EVT);
            fiq_q  <= 1'b1;
        end else begin
            mask_q <= mask_d;
            irq_q  <= irq_d;
            fiq_q  <= |mask_d;
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;
    assign fiq_o  = fiq_q;
endmodule

// File: rtl/snd_evt_run.sv
module snd_evt_run (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic bit_i,
    output logic hold_o,
    output logic pulse_o
);
    logic hold_q, pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit_i && hold_q && !bit_i;
            if (hit_i) begin
                hold_q <= bit_i;
            end
        end
    end

    assign hold_o  = hold_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/snd_evt_irq.sv
module snd_evt_irq
    import snd_evt_irq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ACK_WRITES = 4,
    parameter int unsigned BOOT_EVT   = 2,
    parameter int unsigned RUN_ADDR   = 0,
    parameter int unsigned IRQ_ADDR   = 1,
    parameter int unsigned ACK_ADDR   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fiq_o,
    output logic              cpu_hold_o,
    output logic              core_rst_o,
    output logic              smp_clr_o
);
    localparam int unsigned CNT_W = $clog2(ACK_WRITES + 1);

    function automatic reg_sel_t decode(logic [ADDR_W-1:0] a);
        if (a == ADDR_W'(RUN_ADDR)) return SEL_RUN;
        if (a == ADDR_W'(IRQ_ADDR)) return SEL_IRQ;
        if (a == ADDR_W'(ACK_ADDR)) return SEL_ACK;
        return SEL_NONE;
    endfunction

    reg_sel_t   wr_sel, rd_sel;
    logic       ack_hit, run_hit, clr_fire, rel_pulse;
    logic [CNT_W-1:0] ack_cnt;
    evt_mask_t  pend_mask;
    evt_idx_t   irq_num;

    assign wr_sel  = decode(wr_addr);
    assign rd_sel  = decode(rd_addr);
    assign ack_hit = wr_en && (wr_sel == SEL_ACK);
    assign run_hit = wr_en && (wr_sel == SEL_RUN);

    snd_evt_ack #(.ACK_WRITES(ACK_WRITES)) u_ack (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (ack_hit),
        .fire_o (clr_fire),
        .cnt_o  (ack_cnt)
    );

    snd_evt_pend #(.BOOT_EVT(BOOT_EVT)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .clr_i  (clr_fire),
        .mask_o (pend_mask),
        .irq_o  (irq_num),
        .fiq_o  (fiq_o)
    );

    snd_evt_run u_run (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (run_hit),
        .bit_i   (wr_data[0]),
        .hold_o  (cpu_hold_o),
        .pulse_o (rel_pulse)
    );

    assign core_rst_o = rel_pulse;
    assign smp_clr_o  = rel_pulse;

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_RUN: rd_data[0]       = cpu_hold_o;
            SEL_IRQ: rd_data[IDX_W-1:0] = irq_num;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/snd_evt_irq_chk.sv
module snd_evt_irq_chk
    import snd_evt_irq_pkg::*;
#(
    parameter int unsigned ACK_WRITES = 4,
    parameter int unsigned CNT_W      = 3
) (
    input logic             clk,
    input logic             rst,
    input evt_mask_t        pend_mask,
    input logic             clr_fire,
    input logic [CNT_W-1:0] ack_cnt,
    input logic             fiq_o,
    input logic             cpu_hold_o,
    input logic             core_rst_o,
    input logic             smp_clr_o
);
    // R4
    fiq_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_o == (pend_mask != '0));

    // R5
    ack_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        ack_cnt < CNT_W'(ACK_WRITES));

    // R6
    clear_drops_one_chk: assert property (@(posedge clk) disable iff (rst)
        clr_fire |=> ($countones($past(pend_mask) & ~pend_mask) <= 1));

    // R2
    no_loss_without_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_fire |=> (($past(pend_mask) & ~pend_mask) == '0));

    // R7
    release_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |=> !core_rst_o);

    // R7
    release_pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> (!cpu_hold_o && $past(cpu_hold_o) && smp_clr_o));
endmodule

bind snd_evt_irq snd_evt_irq_chk #(.ACK_WRITES(ACK_WRITES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pend_mask  (pend_mask),
    .clr_fire   (clr_fire),
    .ack_cnt    (ack_cnt),
    .fiq_o      (fiq_o),
    .cpu_hold_o (cpu_hold_o),
    .core_rst_o (core_rst_o),
    .smp_clr_o  (smp_clr_o)
);

// File: tb/snd_evt_irq_test.sv
`timescale 1ns/1ps
module snd_evt_irq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_i = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = 4'd1;
    logic [7:0] rd_data;
    logic       fiq_o, cpu_hold_o, core_rst_o, smp_clr_o;

    int checks = 0;
    int fails  = 0;

    // expected state
    logic [7:0] m_mask;
    logic [2:0] m_irq;
    logic [2:0] m_cnt;
    logic       m_hold;
    logic       m_pulse;

    always #5 clk = ~clk;

    snd_evt_irq uut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fiq_o(fiq_o),
        .cpu_hold_o(cpu_hold_o), .core_rst_o(core_rst_o), .smp_clr_o(smp_clr_o)
    );

    function automatic int low_bit(logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_read(logic [3:0] a);
        if (a == 4'd0) return {7'd0, m_hold};
        if (a == 4'd1) return {5'd0, m_irq};
        return 8'd0;
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance the reference by one cycle from the requirements.
    task automatic model(logic [7:0] ev, logic we, logic [3:0] wa, logic [7:0] wd);
        logic fire;
        int   lo, ar;
        fire = 1'b0;
        if (we && wa == 4'd2) begin                     // R5
            if (m_cnt == 3'd3) begin fire = 1'b1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        if (fire && m_mask != 0) begin                  // R6, R9
            lo = low_bit(m_mask);
            m_mask[lo] = 1'b0;
            if (m_mask != 0) m_irq = 3'(low_bit(m_mask));
        end
        ar = low_bit(ev);                               // R3
        if (ar >= 0 && (m_irq == 0 || ar < int'(m_irq))) m_irq = 3'(ar);
        m_mask = m_mask | ev;                           // R2
        m_pulse = 1'b0;
        if (we && wa == 4'd0) begin                     // R7
            m_pulse = m_hold && !wd[0];
            m_hold  = wd[0];
        end
    endtask

    task automatic step(string req, logic [7:0] ev, logic we, logic [3:0] wa,
                        logic [7:0] wd, logic [3:0] ra);
        evt_i = ev; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        model(ev, we, wa, wd);
        @(posedge clk); #2;
        chk(req, "fiq", {7'd0, fiq_o}, {7'd0, m_mask != 0});
        chk(req, "hold", {7'd0, cpu_hold_o}, {7'd0, m_hold});
        chk(req, "core_rst", {7'd0, core_rst_o}, {7'd0, m_pulse});
        chk(req, "smp_clr", {7'd0, smp_clr_o}, {7'd0, m_pulse});
        chk(req, "rd_data", rd_data, exp_read(ra));
        chk(req, "irq", (rd_addr == 4'd1) ? rd_data : {5'd0, m_irq}, {5'd0, m_irq});
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0;
    endtask

    task automatic ack_once(string req);
        step(req, 8'h00, 1'b1, 4'd2, 8'h00, 4'd1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        m_mask = 8'h04; m_irq = 3'd2; m_cnt = 0; m_hold = 1'b1; m_pulse = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "fiq", {7'd0, fiq_o}, 8'd1);
        chk("R1", "irq", rd_data, 8'd2);
        chk("R1", "pulse", {7'd0, core_rst_o | smp_clr_o}, 8'd0);
        rd_addr = 4'd0; #1;
        chk("R1", "hold", rd_data, 8'd1);

        // R5: three writes do nothing, fourth clears the only bit (R6 irq kept)
        repeat (3) ack_once("R5");
        ack_once("R6");
        chk("R4", "fiq empty", {7'd0, fiq_o}, 8'd0);
        // R5: writes to other addresses do not count
        step("R5", 8'h00, 1'b1, 4'd3, 8'hFF, 4'd3);
        step("R5", 8'h00, 1'b1, 4'd1, 8'hFF, 4'd1);
        // R4 event into empty mask, R3 stale 2 blocks 5
        step("R4", 8'h20, 1'b0, 4'd0, 8'h00, 4'd1);
        // R2 simultaneous events
        step("R2", 8'h48, 1'b0, 4'd0, 8'h00, 4'd1);
        repeat (4) ack_once("R6");
        step("R3", 8'h01, 1'b0, 4'd0, 8'h00, 4'd1);
        step("R3", 8'h10, 1'b0, 4'd0, 8'h00, 4'd1);
        // R9 clear coinciding with event
        repeat (3) ack_once("R9");
        step("R9", 8'h82, 1'b1, 4'd2, 8'h00, 4'd1);
        // R7 control transitions
        step("R7", 8'h00, 1'b1, 4'd0, 8'h00, 4'd0);
        step("R7", 8'h00, 1'b0, 4'd0, 8'h00, 4'd0);
        step("R7", 8'h00, 1'b1, 4'd0, 8'h00, 4'd0);
        step("R7", 8'h00, 1'b1, 4'd0, 8'h01, 4'd0);
        step("R7", 8'h00, 1'b1, 4'd0, 8'hFF, 4'd0);
        step("R7", 8'h00, 1'b1, 4'd0, 8'hFE, 4'd0);
        // R8 reads of unused address
        step("R8", 8'h00, 1'b0, 4'd0, 8'h00, 4'd9);

        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ev;
            logic       we;
            logic [3:0] wa;
            ev = ($urandom % 5 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            we = ($urandom % 2) == 0;
            wa = ($urandom % 4 == 0) ? 4'($urandom) : 4'd2;
            if ($urandom % 8 == 0) wa = 4'd0;
            step("R3", ev, we, wa, 8'($urandom), 4'($urandom % 4));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule